// File: doc/BRIEF.md
# Vector Register Move-Merge Unit

This block carries data between a small file of 128-bit vector registers and a memory port. Every register is seen as two 64-bit lanes: the low lane in bits 63:0 and the high lane in bits 127:64. A decoded operation code picks one move each cycle. The moves are: full-width loads, stores and register copies, in an alignment-checked form and an unchecked form. There are also scalar moves of the low lane, lane loads that merge into one half of a register, lane stores, and a sign-mask extraction that returns the two lane sign bits as a small integer.

The caller presents one operation per cycle with its register indices, its byte address and the memory read data for that address. One clock edge later the unit reports what it did. This report can be a register writeback, a memory write with byte enables, a mask result, or a fault. A faulting operation changes neither the register file nor memory. The register file is held inside the block. Its contents reach the outside only through stores, writeback reports and mask results.

Top module: `vreg_move_unit`

## Requirements
- R1: A synchronous active-low reset clears every register to zero and drives every output to zero.
- R2: Opcode encoding: 0 no-op, 1 checked full load, 2 checked full store, 3 checked full copy, 4 free full load, 5 free full store, 6 free full copy, 7 scalar load, 8 scalar store, 9 scalar copy, 10 high-lane load, 11 high-lane store, 12 low-lane load, 13 low-lane store, 14 sign mask. Codes 0 and 15, and any cycle with op_valid low, change no state and produce no output.
- R3: All outputs are registered. The result of an operation presented in one cycle appears after the next rising edge. A written register takes its new value at that same edge.
- R4: The checked full load and store move all 128 bits, and they fault when addr[3:0] is not zero. The checked full copy ignores the address and never faults.
- R5: The free full load, store and copy move all 128 bits at any address and never fault.
- R6: A 64-bit memory access uses the half of mem_rdata or mem_wdata selected by addr[3]: bits 63:0 when it is 0, bits 127:64 when it is 1. A lane store drives zeros in the other half.
- R7: The scalar load writes the selected 64-bit memory value to the low lane and zero to the high lane. The scalar copy writes the source low lane into the destination low lane and keeps the destination high lane. The scalar store writes the source low lane to memory.
- R8: The high-lane load replaces only the high lane, and the low-lane load replaces only the low lane. The other lane of the destination keeps its value.
- R9: The high-lane and low-lane stores write the source register's high or low lane to memory.
- R10: Every 64-bit memory operation (opcodes 7, 8, 10 to 13) faults when align_chk_en is 1 and addr[2:0] is not zero. It never faults when align_chk_en is 0.
- R11: In the cycle fault is high, wb_en and mem_we are low, and the register file keeps its contents.
- R12: mem_be bit i enables mem_wdata byte i. A full store sets all 16 enables. A lane store sets 16'h00FF when addr[3] is 0 and 16'hFF00 when it is 1.
- R13: The sign mask reports bit 63 of the source register in mask_bits[0] and bit 127 in mask_bits[1], with mask_valid high. It does not write a register or memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation code (R2) |
| src_idx | input | 3 | Source register index |
| dst_idx | input | 3 | Destination register index |
| addr | input | 32 | Byte address of the memory access |
| mem_rdata | input | 128 | Memory data for the load at addr |
| align_chk_en | input | 1 | Enables alignment checks on 64-bit accesses |
| wb_en | output | 1 | A register was written |
| wb_idx | output | 3 | Index of the written register |
| wb_data | output | 128 | Value written to that register |
| mem_we | output | 1 | Memory write request |
| mem_be | output | 16 | Byte enables of the write |
| mem_wdata | output | 128 | Write data |
| mask_valid | output | 1 | mask_bits holds a sign mask |
| mask_bits | output | 2 | Lane sign bits |
| fault | output | 1 | The operation faulted and was suppressed |

## Verification
The bench runs every opcode at every low address offset, with alignment checking both on and off, and compares the results against an arithmetic model of the register file. The sweep covers misaligned checked loads. A design that let them through would show a stray writeback where a fault was due. The free moves are run at odd offsets, where a wrongly added check would fault. The merges are run on registers that already hold data, so a lane load or scalar copy that clobbers the wrong half, or a scalar load that keeps the high lane, returns a mismatched wb_data. Stores are run with both values of addr[3], so swapped lane placement or byte enables show up on the memory side. A closing set of full stores reads every register back, which exposes any write that a fault should have suppressed.

// File: rtl/vmm_pkg.sv
// Package: shared widths and the operation encoding of the move-merge unit.
// Assumes byte addressing and a vector made of exactly two lanes.
package vmm_pkg;
    localparam int LANE_W  = 64;
    localparam int VEC_W   = 2 * LANE_W;
    localparam int BE_W    = VEC_W / 8;
    localparam int LANE_AB = $clog2(LANE_W / 8);   // address bits inside a lane
    localparam int VEC_AB  = $clog2(VEC_W / 8);    // address bits inside a vector

    typedef enum logic [3:0] {
        OP_NONE   = 4'd0,
        OP_CA_LD  = 4'd1,
        OP_CA_ST  = 4'd2,
        OP_CA_RR  = 4'd3,
        OP_FR_LD  = 4'd4,
        OP_FR_ST  = 4'd5,
        OP_FR_RR  = 4'd6,
        OP_SC_LD  = 4'd7,
        OP_SC_ST  = 4'd8,
        OP_SC_RR  = 4'd9,
        OP_HI_LD  = 4'd10,
        OP_HI_ST  = 4'd11,
        OP_LO_LD  = 4'd12,
        OP_LO_ST  = 4'd13,
        OP_SGNMSK = 4'd14
    } vmm_op_e;
endpackage

// File: rtl/vmm_regfile.sv
// Module: vector register file with one write port and two read ports.
// Assumes reads are combinational and a write lands at the clock edge.
module vmm_regfile #(
    parameter int NREGS = 8,
    parameter int W     = 128,
    localparam int IW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] ra_idx,
    output logic [W-1:0]  ra_data,
    input  logic [IW-1:0] rb_idx,
    output logic [W-1:0]  rb_data
);
    logic [W-1:0] regs [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_entry
        // Hold one register; clear on reset, load when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && widx == IW'(g))
                regs[g] <= wdata;
        end
    end

    // Read ports.
    always_comb begin
        ra_data = regs[ra_idx];
        rb_data = regs[rb_idx];
    end
endmodule

// File: rtl/vmm_align_chk.sv
// Module: alignment fault decision for one operation.
// Assumes only the low in-vector address bits matter; register copies never fault.
module vmm_align_chk
    import vmm_pkg::*;
(
    input  vmm_op_e           op,
    input  logic [VEC_AB-1:0] addr_lo,
    input  logic              chk_en,
    output logic              fault
);
    logic mis_vec, mis_lane;

    // Misalignment against vector and lane boundaries.
    always_comb begin
        mis_vec  = addr_lo != '0;
        mis_lane = addr_lo[LANE_AB-1:0] != '0;
    end

    // Per-operation fault rule.
    always_comb begin
        case (op)
            OP_CA_LD, OP_CA_ST:                   fault = mis_vec;
            OP_SC_LD, OP_SC_ST, OP_HI_LD,
            OP_HI_ST, OP_LO_LD, OP_LO_ST:         fault = chk_en && mis_lane;
            default:                              fault = 1'b0;
        endcase
    end
endmodule

// File: rtl/vmm_lane_merge.sv
// Module: builds writeback value, store data and byte enables, and the sign mask.
// Assumes half_sel selects which half of the memory bus a 64-bit access uses.
module vmm_lane_merge
    import vmm_pkg::*;
(
    input  vmm_op_e           op,
    input  logic              half_sel,
    input  logic [VEC_W-1:0]  src_val,
    input  logic [VEC_W-1:0]  dst_val,
    input  logic [VEC_W-1:0]  rdata,
    output logic              wb_req,
    output logic [VEC_W-1:0]  wb_val,
    output logic              st_req,
    output logic [BE_W-1:0]   st_be,
    output logic [VEC_W-1:0]  st_data,
    output logic              msk_req,
    output logic [1:0]        msk_val
);
    localparam int HB = BE_W / 2;

    logic [LANE_W-1:0] mem_lane;
    logic [LANE_W-1:0] st_lane;
    logic [BE_W-1:0]   lane_be;
    logic [VEC_W-1:0]  lane_data;

    // Pick the 64-bit memory half and place a 64-bit store value.
    always_comb begin
        mem_lane  = half_sel ? rdata[VEC_W-1:LANE_W] : rdata[LANE_W-1:0];
        st_lane   = (op == OP_HI_ST) ? src_val[VEC_W-1:LANE_W] : src_val[LANE_W-1:0];
        lane_be   = half_sel ? {{HB{1'b1}}, {HB{1'b0}}} : {{HB{1'b0}}, {HB{1'b1}}};
        lane_data = half_sel ? {st_lane, {LANE_W{1'b0}}} : {{LANE_W{1'b0}}, st_lane};
    end

    // Per-operation data path.
    always_comb begin
        wb_req  = 1'b0;
        wb_val  = '0;
        st_req  = 1'b0;
        st_be   = '0;
        st_data = '0;
        msk_req = 1'b0;
        msk_val = '0;
        case (op)
            OP_CA_LD, OP_FR_LD: begin
                wb_req = 1'b1;
                wb_val = rdata;
            end
            OP_CA_RR, OP_FR_RR: begin
                wb_req = 1'b1;
                wb_val = src_val;
            end
            OP_CA_ST, OP_FR_ST: begin
                st_req  = 1'b1;
                st_be   = '1;
                st_data = src_val;
            end
            OP_SC_LD: begin
                wb_req = 1'b1;
                wb_val = {{LANE_W{1'b0}}, mem_lane};
            end
            OP_SC_RR: begin
                wb_req = 1'b1;
                wb_val = {dst_val[VEC_W-1:LANE_W], src_val[LANE_W-1:0]};
            end
            OP_HI_LD: begin
                wb_req = 1'b1;
                wb_val = {mem_lane, dst_val[LANE_W-1:0]};
            end
            OP_LO_LD: begin
                wb_req = 1'b1;
                wb_val = {dst_val[VEC_W-1:LANE_W], mem_lane};
            end
            OP_SC_ST, OP_HI_ST, OP_LO_ST: begin
                st_req  = 1'b1;
                st_be   = lane_be;
                st_data = lane_data;
            end
            OP_SGNMSK: begin
                msk_req = 1'b1;
                msk_val = {src_val[VEC_W-1], src_val[LANE_W-1]};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vreg_move_unit.sv
// Module: top of the vector register move-merge unit.
// Assumes one operation per cycle and mem_rdata valid in the same cycle as the op;
// all results are registered and appear one edge later.
module vreg_move_unit
    import vmm_pkg::*;
#(
    parameter int NREGS = 8,
    parameter int AW    = 32,
    localparam int IW   = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [3:0]       op_code,
    input  logic [IW-1:0]    src_idx,
    input  logic [IW-1:0]    dst_idx,
    input  logic [AW-1:0]    addr,
    input  logic [VEC_W-1:0] mem_rdata,
    input  logic             align_chk_en,
    output logic             wb_en,
    output logic [IW-1:0]    wb_idx,
    output logic [VEC_W-1:0] wb_data,
    output logic             mem_we,
    output logic [BE_W-1:0]  mem_be,
    output logic [VEC_W-1:0] mem_wdata,
    output logic             mask_valid,
    output logic [1:0]       mask_bits,
    output logic             fault
);
    vmm_op_e          op;
    logic             flt_c, wb_req, st_req, msk_req, rf_we;
    logic [VEC_W-1:0] src_val, dst_val, wb_val, st_data;
    logic [BE_W-1:0]  st_be;
    logic [1:0]       msk_val;
    logic             unused_addr_hi;

    // Turn an idle cycle into a no-op.
    always_comb begin
        op             = op_valid ? vmm_op_e'(op_code) : OP_NONE;
        unused_addr_hi = ^addr[AW-1:VEC_AB];
    end

    vmm_regfile #(.NREGS(NREGS), .W(VEC_W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .widx    (dst_idx),
        .wdata   (wb_val),
        .ra_idx  (src_idx),
        .ra_data (src_val),
        .rb_idx  (dst_idx),
        .rb_data (dst_val)
    );

    vmm_align_chk u_chk (
        .op      (op),
        .addr_lo (addr[VEC_AB-1:0]),
        .chk_en  (align_chk_en),
        .fault   (flt_c)
    );

    vmm_lane_merge u_merge (
        .op       (op),
        .half_sel (addr[LANE_AB]),
        .src_val  (src_val),
        .dst_val  (dst_val),
        .rdata    (mem_rdata),
        .wb_req   (wb_req),
        .wb_val   (wb_val),
        .st_req   (st_req),
        .st_be    (st_be),
        .st_data  (st_data),
        .msk_req  (msk_req),
        .msk_val  (msk_val)
    );

    // A fault suppresses the register write.
    always_comb rf_we = wb_req && !flt_c;

    // Register the result report, gated by the fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_en      <= 1'b0;
            wb_idx     <= '0;
            wb_data    <= '0;
            mem_we     <= 1'b0;
            mem_be     <= '0;
            mem_wdata  <= '0;
            mask_valid <= 1'b0;
            mask_bits  <= '0;
            fault      <= 1'b0;
        end else begin
            wb_en      <= rf_we;
            wb_idx     <= rf_we ? dst_idx : '0;
            wb_data    <= rf_we ? wb_val : '0;
            mem_we     <= st_req && !flt_c;
            mem_be     <= flt_c ? '0 : st_be;
            mem_wdata  <= flt_c ? '0 : st_data;
            mask_valid <= msk_req;
            mask_bits  <= msk_val;
            fault      <= flt_c;
        end
    end
endmodule

// File: rtl/vmm_checker.sv
// Module: property checker for vreg_move_unit, attached by bind.
// Assumes the default opcode encoding of vmm_pkg.
module vmm_checker
    import vmm_pkg::*;
#(
    parameter int AW = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [3:0]       op_code,
    input logic [AW-1:0]    addr,
    input logic [VEC_W-1:0] mem_rdata,
    input logic             align_chk_en,
    input logic             wb_en,
    input logic [VEC_W-1:0] wb_data,
    input logic             mem_we,
    input logic [BE_W-1:0]  mem_be,
    input logic             mask_valid,
    input logic             fault
);
    // R11: a fault never comes with a write.
    a_r11_fault_blocks_writes: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !wb_en && !mem_we);

    // R4: misaligned checked full load or store faults.
    a_r4_checked_misalign: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 4'(OP_CA_LD) || op_code == 4'(OP_CA_ST))
         && addr[VEC_AB-1:0] != '0) |=> fault);

    // R5: free full moves never fault.
    a_r5_free_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 4'(OP_FR_LD) || op_code == 4'(OP_FR_ST)
         || op_code == 4'(OP_FR_RR))) |=> !fault);

    // R10: with checking off, lane accesses never fault.
    a_r10_unchecked_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !align_chk_en && op_code >= 4'(OP_SC_LD)
         && op_code <= 4'(OP_LO_ST)) |=> !fault);

    // R12: byte enables take one of three legal shapes.
    a_r12_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_be == 16'hFFFF || mem_be == 16'h00FF || mem_be == 16'hFF00));

    // R13: a mask result writes nothing.
    a_r13_mask_only: assert property (@(posedge clk) disable iff (!rst_n)
        mask_valid |-> !wb_en && !mem_we);

    // R7: scalar load clears the high lane.
    a_r7_scalar_clears_high: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !align_chk_en && op_code == 4'(OP_SC_LD))
        |=> wb_en && wb_data[VEC_W-1:LANE_W] == '0);

    // R8: high-lane load takes the selected memory half.
    a_r8_high_load_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !align_chk_en && op_code == 4'(OP_HI_LD) && !addr[LANE_AB])
        |=> wb_en && wb_data[VEC_W-1:LANE_W] == $past(mem_rdata[LANE_W-1:0]));
endmodule

bind vreg_move_unit vmm_checker #(.AW(AW)) u_vmm_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .op_code      (op_code),
    .addr         (addr),
    .mem_rdata    (mem_rdata),
    .align_chk_en (align_chk_en),
    .wb_en        (wb_en),
    .wb_data      (wb_data),
    .mem_we       (mem_we),
    .mem_be       (mem_be),
    .mask_valid   (mask_valid),
    .fault        (fault)
);

// File: tb/vreg_move_unit_tb.sv
// Bench: sweeps every opcode over all low address offsets with checking on and off,
// against an arithmetic model of the register file.
module vreg_move_unit_tb;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         op_valid;
    logic [3:0]   op_code;
    logic [2:0]   src_idx, dst_idx;
    logic [31:0]  addr;
    logic [127:0] mem_rdata;
    logic         align_chk_en;
    logic         wb_en;
    logic [2:0]   wb_idx;
    logic [127:0] wb_data;
    logic         mem_we;
    logic [15:0]  mem_be;
    logic [127:0] mem_wdata;
    logic         mask_valid;
    logic [1:0]   mask_bits;
    logic         fault;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    logic [127:0] mdl [8];

    always #5 clk = ~clk;

    vreg_move_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .src_idx(src_idx), .dst_idx(dst_idx), .addr(addr), .mem_rdata(mem_rdata),
        .align_chk_en(align_chk_en), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
        .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mask_valid(mask_valid), .mask_bits(mask_bits), .fault(fault)
    );

    function automatic string tag_of(input logic [3:0] op, input bit v);
        if (!v) return "R3";
        case (op)
            4'd1, 4'd2, 4'd3: return "R4";
            4'd4, 4'd5, 4'd6: return "R5";
            4'd7, 4'd8, 4'd9: return "R7";
            4'd10, 4'd12:     return "R8";
            4'd11, 4'd13:     return "R9";
            4'd14:            return "R13";
            default:          return "R2";
        endcase
    endfunction

    // Present one operation, check its result one edge later, update the model.
    task automatic run_op(input bit v, input logic [3:0] op, input logic [2:0] s,
                          input logic [2:0] d, input logic [31:0] a,
                          input logic [127:0] rd, input bit ac, input string tag);
        logic ef, ewb, ewe, emv;
        logic [127:0] ewd, ewdat;
        logic [15:0] ebe;
        logic [1:0] emk;
        logic [63:0] lane, sv;
        logic m16, m8;
        bit bad;
        op_valid = v; op_code = op; src_idx = s; dst_idx = d;
        addr = a; mem_rdata = rd; align_chk_en = ac;
        ef = 0; ewb = 0; ewe = 0; emv = 0; ewd = '0; ewdat = '0; ebe = '0; emk = '0;
        lane = a[3] ? rd[127:64] : rd[63:0];
        m16 = a[3:0] != 0;
        m8  = ac && a[2:0] != 0;
        sv  = (op == 4'd11) ? mdl[s][127:64] : mdl[s][63:0];
        if (v) begin
            case (op)
                4'd1:  if (m16) ef = 1; else begin ewb = 1; ewd = rd; end
                4'd2:  if (m16) ef = 1; else begin ewe = 1; ebe = '1; ewdat = mdl[s]; end
                4'd3, 4'd6: begin ewb = 1; ewd = mdl[s]; end
                4'd4:  begin ewb = 1; ewd = rd; end
                4'd5:  begin ewe = 1; ebe = '1; ewdat = mdl[s]; end
                4'd7:  if (m8) ef = 1; else begin ewb = 1; ewd = {64'd0, lane}; end
                4'd9:  begin ewb = 1; ewd = {mdl[d][127:64], mdl[s][63:0]}; end
                4'd10: if (m8) ef = 1; else begin ewb = 1; ewd = {lane, mdl[d][63:0]}; end
                4'd12: if (m8) ef = 1; else begin ewb = 1; ewd = {mdl[d][127:64], lane}; end
                4'd8, 4'd11, 4'd13:
                    if (m8) ef = 1;
                    else begin
                        ewe = 1;
                        ebe = a[3] ? 16'hFF00 : 16'h00FF;
                        ewdat = a[3] ? {sv, 64'd0} : {64'd0, sv};
                    end
                4'd14: begin emv = 1; emk = {mdl[s][127], mdl[s][63]}; end
                default: ;
            endcase
        end
        @(negedge clk);
        op_valid = 0;
        bad = (fault !== ef) || (wb_en !== ewb) || (mem_we !== ewe) || (mask_valid !== emv)
           || (ewb && (wb_idx !== d || wb_data !== ewd))
           || (ewe && (mem_be !== ebe || mem_wdata !== ewdat))
           || (emv && mask_bits !== emk);
        checks++;
        if (bad) begin
            errors++;
            $display("FAIL %s op=%0d a=%h ac=%0b: actual f=%b wb=%b idx=%0d wd=%h we=%b be=%h wdat=%h mv=%b mk=%b expected f=%b wb=%b idx=%0d wd=%h we=%b be=%h wdat=%h mv=%b mk=%b",
                     tag, op, a, ac, fault, wb_en, wb_idx, wb_data, mem_we, mem_be, mem_wdata,
                     mask_valid, mask_bits, ef, ewb, d, ewd, ewe, ebe, ewdat, emv, emk);
        end
        if (ewb) mdl[d] = ewd;
    endtask

    function automatic logic [127:0] pat(input int n);
        return {32'(n * 32'h9E3779B9), 32'(n * 32'h85EBCA6B),
                32'(n * 32'hC2B2AE35), 32'(n * 32'h27D4EB2F)};
    endfunction

    initial begin
        int n;
        rst_n = 0; op_valid = 0; op_code = 0; src_idx = 0; dst_idx = 0;
        addr = 0; mem_rdata = '0; align_chk_en = 0;
        for (int i = 0; i < 8; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        // R1: outputs cleared during reset.
        checks++;
        if (wb_en || mem_we || mask_valid || fault || mem_be != 0 || wb_data != 0) begin
            errors++;
            $display("FAIL R1 reset outputs: actual wb=%b we=%b mv=%b f=%b expected all 0",
                     wb_en, mem_we, mask_valid, fault);
        end
        rst_n = 1;
        // R1: registers read back as zero after reset.
        for (int r = 0; r < 8; r++) run_op(1, 4'd5, 3'(r), 0, 32'h3, '1, 0, "R1");
        // Preload registers with free loads.
        for (int r = 0; r < 8; r++) run_op(1, 4'd4, 0, 3'(r), 32'h7, pat(r + 11), 0, "R5");
        // R3: an idle cycle with a load code changes nothing.
        run_op(0, 4'd4, 0, 3'd2, 32'h0, pat(99), 0, "R3");
        // R2: unused codes do nothing.
        run_op(1, 4'd0, 1, 3'd2, 32'h0, pat(98), 1, "R2");
        run_op(1, 4'd15, 1, 3'd2, 32'h0, pat(97), 1, "R2");
        // Sweep: all opcodes, all offsets, checking on and off (R4-R13).
        n = 100;
        for (int op = 0; op < 16; op++)
            for (int off = 0; off < 16; off++)
                for (int ac = 0; ac < 2; ac++) begin
                    run_op(1, 4'(op), 3'((op + off) % 8), 3'((op * 3 + off + ac + 1) % 8),
                           32'h1000 + 32'(off) + (32'(ac) << 4), pat(n), ac[0],
                           tag_of(4'(op), 1));
                    n++;
                end
        // R6/R12: lane stores to both halves with checking on.
        run_op(1, 4'd11, 3, 0, 32'h28, '0, 1, "R6");
        run_op(1, 4'd13, 3, 0, 32'h20, '0, 1, "R12");
        // R11: final readback shows no write slipped past a fault.
        for (int r = 0; r < 8; r++) run_op(1, 4'd5, 3'(r), 0, 32'h9, '0, 0, "R11");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule